// File: doc/BRIEF.md
# Debug Port Reset Control Register

This block is an eight-bit control register that an external debugger writes and reads. Its bits drive system-wide actions: a whole-array flash erase request, a forced shutdown of the core's debug logic, a halt request to the core, a system reset hold, and a clear strobe for the sticky low-power entry flags. The flash controller, the core debug logic and the power-mode controller sit outside the block. They appear here only as handshake inputs and outputs.

The block also handles the ordering of resets. A configuration bit lets the debugger keep the core in reset after the system reset sequence has finished, and release it later by clearing that bit. A second pair of bits lets the debugger ask that, after a deep low-power mode, the system stays in reset on wake-up until the debugger acknowledges. This gives the debugger time to set up its logic again before any code runs.

Top module: `dbg_rst_ctrl`

## Requirements
- R1: After power-on reset (`por_n_i` low) all eight register bits read 0 and every output is inactive (0).
- R2: A write (`wr_en_i` high) stores `wr_data_i` into bits 1 to 7, subject to R10. `rd_data_o` always shows the current register, with bit n of the bus equal to register bit n.
- R3: Bit 0 (erase request) is write-1-to-set: writing 0 to it has no effect. It is cleared when `erase_done_i` or `rst_seq_i` is high. A clear wins over a set in the same cycle. If neither event happens, it stays 1.
- R4: `erase_req_o` pulses for exactly one cycle, in the cycle right after bit 0 changes from 0 to 1, and only if `erase_en_i` is high in that cycle. If permission is raised later, no request is issued.
- R5: `dbg_off_o` follows bit 1, `halt_req_o` follows bit 2, and `lp_stat_clr_o` follows bit 7.
- R6: `sys_rst_o` is high in every cycle in which bit 3 reads 1.
- R7: `core_rst_o` is high while `rst_seq_i` is high. If bit 4 is 0 when sequencing ends, the core leaves reset in the same cycle that `rst_seq_i` falls. If bit 4 is 1, `core_rst_o` stays high.
- R8: A core held by R7 is released one clock after bit 4 reads 0. Setting bit 4 outside a reset sequence does not put the core in reset.
- R9: Bit 5 is sampled when `lp_enter_i` is high. If the sampled value is 1, `sys_rst_o` rises in the cycle after `lp_exit_i`. It then stays high until one clock after bit 6 reads 1.
- R10: `lp_exit_i` clears bits 5 and 6. This clear overrides a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| wr_en_i | input | 1 | Debugger register write strobe |
| wr_data_i | input | 8 | Debugger write data |
| rd_data_o | output | 8 | Current register value |
| erase_en_i | input | 1 | Mass erase is permitted |
| erase_done_i | input | 1 | Flash controller reports that the erase has finished |
| rst_seq_i | input | 1 | System reset sequencing in progress |
| lp_enter_i | input | 1 | Deep low-power mode entry strobe |
| lp_exit_i | input | 1 | Deep low-power recovery strobe (recovery power-on reset) |
| erase_req_o | output | 1 | Single-cycle mass erase request |
| dbg_off_o | output | 1 | Forces core debug logic off |
| halt_req_o | output | 1 | Halt or wake-to-halt request to the core |
| sys_rst_o | output | 1 | System reset hold, active high |
| core_rst_o | output | 1 | Core reset, active high |
| lp_stat_clr_o | output | 1 | Clear for the sticky low-power entry flags |

## Verification
Assertions check several rules on every cycle. An erase-done or reset-sequence event must leave bit 0 clear. A recovery strobe must clear bits 5 and 6. The erase request must never last longer than one cycle. A held core must drop out of hold once bit 4 is low, and must never enter hold outside sequencing. Bit 3 must always force system reset. A captured request must turn into a reset hold that lasts until the acknowledge. Other behaviours need the bench's ordered scenarios to show them: a 0 written to bit 0 being ignored, late erase permission issuing no request, the one-cycle release latency, and a same-cycle write losing to the recovery clear.

// File: rtl/drc_pkg.sv
package drc_pkg;

    localparam int unsigned CTRL_W = 8;

    localparam int unsigned B_ERASE    = 0;
    localparam int unsigned B_DBG_OFF  = 1;
    localparam int unsigned B_HALT     = 2;
    localparam int unsigned B_SYS_RST  = 3;
    localparam int unsigned B_CORE_HLD = 4;
    localparam int unsigned B_LP_REQ   = 5;
    localparam int unsigned B_LP_ACK   = 6;
    localparam int unsigned B_STAT_CLR = 7;

    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef struct packed {
        logic cap;
        logic hold;
    } lp_st_t;

endpackage

// File: rtl/drc_ctrl_reg.sv
module drc_ctrl_reg
    import drc_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_n_i,
    input  logic  wr_en_i,
    input  ctrl_t wr_data_i,
    input  logic  erase_clr_i,
    input  logic  lp_exit_i,
    output ctrl_t ctrl_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en_i) begin
            for (int unsigned i = 0; i < CTRL_W; i++) begin
                if (i == B_ERASE)
                    ctrl_d[i] = ctrl_q[i] | wr_data_i[i];
                else
                    ctrl_d[i] = wr_data_i[i];
            end
        end
        if (erase_clr_i)
            ctrl_d[B_ERASE] = 1'b0;
        if (lp_exit_i) begin
            ctrl_d[B_LP_REQ] = 1'b0;
            ctrl_d[B_LP_ACK] = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    a_r3_erase_clear: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        erase_clr_i |=> !ctrl_o[B_ERASE]);

    a_r10_exit_clears: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        lp_exit_i |=> (!ctrl_o[B_LP_REQ] && !ctrl_o[B_LP_ACK]));

endmodule

// File: rtl/drc_erase_ctl.sv
module drc_erase_ctl (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic erase_bit_i,
    input  logic erase_en_i,
    input  logic erase_done_i,
    input  logic rst_seq_i,
    output logic erase_clr_o,
    output logic erase_req_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = erase_bit_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)
            prev_q <= 1'b0;
        else
            prev_q <= prev_d;
    end

    assign erase_req_o = erase_bit_i & ~prev_q & erase_en_i;
    assign erase_clr_o = erase_done_i | rst_seq_i;

    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        erase_req_o |=> !erase_req_o);

endmodule

// File: rtl/drc_core_seq.sv
module drc_core_seq (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic rst_seq_i,
    input  logic hold_bit_i,
    output logic core_rst_o
);

    logic held_d, held_q;

    always_comb begin
        if (rst_seq_i)
            held_d = hold_bit_i;
        else
            held_d = held_q & hold_bit_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)
            held_q <= 1'b0;
        else
            held_q <= held_d;
    end

    assign core_rst_o = rst_seq_i | held_q;

    a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!rst_seq_i && held_q && !hold_bit_i) |=> !held_q);

    a_r8_no_spurious_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!rst_seq_i && !held_q) |=> !held_q);

endmodule

// File: rtl/drc_lp_hold.sv
module drc_lp_hold
    import drc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic lp_enter_i,
    input  logic lp_exit_i,
    input  logic req_bit_i,
    input  logic ack_bit_i,
    input  logic sys_rst_bit_i,
    output logic sys_rst_o
);

    lp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lp_enter_i)
            st_d.cap = req_bit_i;
        if (lp_exit_i) begin
            st_d.hold = st_q.cap;
            st_d.cap  = 1'b0;
        end else if (ack_bit_i) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign sys_rst_o = sys_rst_bit_i | st_q.hold;

    a_r9_hold_on_exit: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (lp_exit_i && st_q.cap) |=> sys_rst_o);

    a_r9_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q.hold && !ack_bit_i && !lp_exit_i) |=> st_q.hold);

endmodule

// File: rtl/dbg_rst_ctrl.sv
module dbg_rst_ctrl
    import drc_pkg::*;
(
    input  logic       clk_i,
    input  logic       por_n_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       erase_en_i,
    input  logic       erase_done_i,
    input  logic       rst_seq_i,
    input  logic       lp_enter_i,
    input  logic       lp_exit_i,
    output logic       erase_req_o,
    output logic       dbg_off_o,
    output logic       halt_req_o,
    output logic       sys_rst_o,
    output logic       core_rst_o,
    output logic       lp_stat_clr_o
);

    ctrl_t ctrl;
    logic  erase_clr;

    drc_ctrl_reg i_reg (
        .clk_i       (clk_i),
        .rst_n_i     (por_n_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .erase_clr_i (erase_clr),
        .lp_exit_i   (lp_exit_i),
        .ctrl_o      (ctrl)
    );

    drc_erase_ctl i_erase (
        .clk_i        (clk_i),
        .rst_n_i      (por_n_i),
        .erase_bit_i  (ctrl[B_ERASE]),
        .erase_en_i   (erase_en_i),
        .erase_done_i (erase_done_i),
        .rst_seq_i    (rst_seq_i),
        .erase_clr_o  (erase_clr),
        .erase_req_o  (erase_req_o)
    );

    drc_core_seq i_core (
        .clk_i      (clk_i),
        .rst_n_i    (por_n_i),
        .rst_seq_i  (rst_seq_i),
        .hold_bit_i (ctrl[B_CORE_HLD]),
        .core_rst_o (core_rst_o)
    );

    drc_lp_hold i_lp (
        .clk_i         (clk_i),
        .rst_n_i       (por_n_i),
        .lp_enter_i    (lp_enter_i),
        .lp_exit_i     (lp_exit_i),
        .req_bit_i     (ctrl[B_LP_REQ]),
        .ack_bit_i     (ctrl[B_LP_ACK]),
        .sys_rst_bit_i (ctrl[B_SYS_RST]),
        .sys_rst_o     (sys_rst_o)
    );

    assign rd_data_o     = ctrl;
    assign dbg_off_o     = ctrl[B_DBG_OFF];
    assign halt_req_o    = ctrl[B_HALT];
    assign lp_stat_clr_o = ctrl[B_STAT_CLR];

    a_r6_sysrst_bit: assert property (@(posedge clk_i) disable iff (!por_n_i)
        rd_data_o[B_SYS_RST] |-> sys_rst_o);

endmodule

// File: tb/test_dbg_rst_ctrl.sv
module test_dbg_rst_ctrl;

    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic       een;
        logic       edone;
        logic       seq;
        logic       lpin;
        logic       lpout;
        logic [7:0] erd;
        logic       esys;
        logic       ecore;
        logic       ereq;
    } vec_t;

    localparam int NV = 27;
    // fields: wr wd een edone seq lpin lpout | rd sys core ereq
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06, 1'b0, 1'b0, 1'b0}, // R2
        '{1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h08, 1'b1, 1'b0, 1'b0}, // R6
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R6
        '{1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b1}, // R4
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R4
        '{1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R3
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R3
        '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R4
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R4
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // R3 R7
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R7
        '{1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0}, // R8
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 1'b0, 1'b1, 1'b0}, // R7
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0, 1'b1, 1'b0}, // R7
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0, 1'b1, 1'b0}, // R7
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // R8
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R8
        '{1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20, 1'b0, 1'b0, 1'b0}, // R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h20, 1'b0, 1'b0, 1'b0}, // R9
        '{1'b1, 8'h60, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0}, // R10 R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}, // R9
        '{1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40, 1'b1, 1'b0, 1'b0}, // R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40, 1'b0, 1'b0, 1'b0}, // R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h40, 1'b0, 1'b0, 1'b0}, // R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // R10
        '{1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0}, // R2
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}  // R2
    };

    logic       clk = 1'b0;
    logic       por_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       erase_en, erase_done, rst_seq, lp_enter, lp_exit;
    logic       erase_req, dbg_off, halt_req, sys_rst, core_rst, lp_stat_clr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    dbg_rst_ctrl i_dbg_rst_ctrl (
        .clk_i         (clk),
        .por_n_i       (por_n),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .rd_data_o     (rd_data),
        .erase_en_i    (erase_en),
        .erase_done_i  (erase_done),
        .rst_seq_i     (rst_seq),
        .lp_enter_i    (lp_enter),
        .lp_exit_i     (lp_exit),
        .erase_req_o   (erase_req),
        .dbg_off_o     (dbg_off),
        .halt_req_o    (halt_req),
        .sys_rst_o     (sys_rst),
        .core_rst_o    (core_rst),
        .lp_stat_clr_o (lp_stat_clr)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_data = 8'h00; erase_en = 1'b0; erase_done = 1'b0;
        rst_seq = 1'b0; lp_enter = 1'b0; lp_exit = 1'b0;
    endtask

    initial begin
        idle_inputs();
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "rd_data",  rd_data, 8'h00);
        check("R1", "sys_rst",  {7'd0, sys_rst}, 8'h00);
        check("R1", "core_rst", {7'd0, core_rst}, 8'h00);
        check("R1", "outputs",  {3'd0, erase_req, dbg_off, halt_req, lp_stat_clr, 1'b0}, 8'h00);

        for (int k = 0; k < NV; k++) begin
            wr_en = VECS[k].wr;     wr_data = VECS[k].wd;
            erase_en = VECS[k].een; erase_done = VECS[k].edone;
            rst_seq = VECS[k].seq;  lp_enter = VECS[k].lpin;
            lp_exit = VECS[k].lpout;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R2 vec%0d", k), "rd_data",   rd_data, VECS[k].erd);
            check($sformatf("R6/R9 vec%0d", k), "sys_rst", {7'd0, sys_rst}, {7'd0, VECS[k].esys});
            check($sformatf("R7/R8 vec%0d", k), "core_rst", {7'd0, core_rst}, {7'd0, VECS[k].ecore});
            check($sformatf("R4 vec%0d", k), "erase_req", {7'd0, erase_req}, {7'd0, VECS[k].ereq});
        end

        // R5: level outputs follow their bits
        idle_inputs();
        wr_en = 1'b1; wr_data = 8'h86;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        check("R5", "dbg_off",     {7'd0, dbg_off}, 8'h01);
        check("R5", "halt_req",    {7'd0, halt_req}, 8'h01);
        check("R5", "lp_stat_clr", {7'd0, lp_stat_clr}, 8'h01);

        // R3: unpermitted erase request stays set for many cycles
        wr_en = 1'b1; wr_data = 8'h01;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        repeat (20) @(negedge clk);
        check("R3", "bit0 held", {7'd0, rd_data[0]}, 8'h01);
        check("R4", "no late req", {7'd0, erase_req}, 8'h00);

        // R3: clear wins over same-cycle set
        erase_done = 1'b1; wr_en = 1'b1; wr_data = 8'h01;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        check("R3", "clear wins", {7'd0, rd_data[0]}, 8'h00);

        // R1: power-on reset mid-run clears everything
        wr_en = 1'b1; wr_data = 8'h3E;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        check("R6", "sys_rst before por", {7'd0, sys_rst}, 8'h01);
        por_n = 1'b0;
        #2;
        check("R1", "rd after por", rd_data, 8'h00);
        check("R1", "sys_rst after por", {7'd0, sys_rst}, 8'h00);
        check("R1", "halt after por", {7'd0, halt_req}, 8'h00);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule